// File: doc/BRIEF.md
# Write-Through Data Cache Controller with Per-Word Valid Bits

The block is a small direct-mapped data cache that sits between a CPU port and a memory port. It handles one word per CPU request. Every store goes to memory, so memory always holds the current data. Each line keeps a tag and one valid bit per word. Because of these per-word valid bits, a store that misses can claim a line without first reading that line from memory.

A configuration input picks how a store miss is handled. There are three choices:
- fetch the block, then write the word;
- send the word to memory only;
- claim the line and mark only the stored word valid.

A second input enables speculative stores. When it is set, the word is written into the indexed line in the same cycle the request is accepted, before the tag result is known. If the tag check then reports a miss, the controller repairs that speculative write according to the selected policy.

On the memory side there are two ports. A one-word write port is held until the memory acknowledges. A block read port issues a single request, and the words of the block then return one per beat, in order, after however many cycles the memory takes. The CPU sees `cpu_ready` low for as long as any request is in flight.

Top module: `wt_cache_ctrl`

## Requirements
- R1: After reset every valid bit is clear, `cpu_ready` is high and no memory request is active, so the first access to any address misses.
- R2: A read hits only when the line tag matches and that word's valid bit is set. A hit returns the cached word with no memory traffic, and `cpu_ready` is low for exactly one cycle.
- R3: A read miss issues one single-cycle block request for the aligned block. It fills all LINE_WORDS words (beat k goes to word offset k), sets every valid bit of the line and returns the requested word.
- R4: A store to a present line writes the cache word, sets its valid bit and writes the word to memory exactly once. A line is present when the tag matches and at least one valid bit is set.
- R5: A store miss with policy code 0 (fetch) reads the whole block, merges the stored word and sets all valid bits. It then writes the word to memory.
- R6: A store miss with policy code 1 (around), with speculative stores disabled, writes memory only and leaves the cached line, its tag and its valid bits unchanged.
- R7: A store miss with policy code 2 (validate) sets the new tag and leaves only the stored word valid, with no block read. It then writes the word to memory.
- R8: With speculative stores enabled and the around policy, a miss clears the valid bit of the overwritten word in the old line. The other words of that line stay valid, and the store goes to memory.
- R9: With speculative stores enabled and an allocating policy (codes 0 and 2), a miss keeps the stored word in the newly allocated line and writes it to memory.
- R10: Memory writes happen one at a time. `mem_wr_req` together with its address and data is held stable until `mem_wr_ack`. `cpu_ready` is low while any memory request is active.
- R11: The policy and the speculative-store setting are sampled when a request is accepted, so changes made while the controller is busy do not affect that request. Policy code 3 behaves as code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Request, accepted when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Data of the last completed load |
| cpu_ready | output | 1 | Idle and able to accept a request |
| wr_policy | input | 2 | Store-miss policy: 0 fetch, 1 around, 2 validate, 3 around |
| spec_write | input | 1 | Write the array before the tag check |
| mem_rd_req | output | 1 | One-cycle block read request |
| mem_rd_blk | output | ADDR_W-log2(LINE_WORDS) | Block address |
| mem_rd_valid | input | 1 | Read beat valid |
| mem_rd_data | input | DATA_W | Read beat data, offsets in ascending order |
| mem_wr_req | output | 1 | Word write request, held until acknowledged |
| mem_wr_addr | output | ADDR_W | Word write address |
| mem_wr_data | output | DATA_W | Word write data |
| mem_wr_ack | input | 1 | Word write accepted |

## Verification
The bench targets the repair of a speculative store that misses under the around policy. A design that forgets to clear the overwritten word's valid bit returns the store data for a later load of the old address. The bench also looks at lines left partly valid by the validate policy. A design that treats a tag match alone as a read hit returns stale array contents instead of refilling. Further checks count block reads and word writes per request, which catches a fetch-on-write that skips the fetch, a store that writes memory twice, and a load hit that takes extra cycles. A policy change in the middle of a request confirms that the policy is sampled at acceptance.

// File: rtl/wtc_pkg.sv
// Shared types for the write-through cache controller.
package wtc_pkg;
    // Store-miss policy codes; code 3 is treated like write-around.
    typedef enum logic [1:0] {
        POL_FETCH    = 2'd0,
        POL_AROUND   = 2'd1,
        POL_VALIDATE = 2'd2,
        POL_AROUND2  = 2'd3
    } wpol_e;

    // Controller states.
    typedef enum logic [2:0] {
        ST_IDLE, ST_LOOK, ST_FREQ, ST_FILL, ST_WMEM
    } cst_e;

    // Operations on the tag / valid store.
    typedef enum logic [1:0] {
        TV_NONE, TV_SETW, TV_CLRW, TV_ALLOC
    } tvop_e;
endpackage

// File: rtl/wtc_tagvalid.sv
// Tag and per-word valid store, one entry per line.
// Assumes one operation per cycle on the line op_idx; reads are combinational.
module wtc_tagvalid
    import wtc_pkg::*;
#(
    parameter int LINES      = 4,
    parameter int LINE_WORDS = 4,
    parameter int TAG_W      = 4,
    localparam int IDX_W     = $clog2(LINES),
    localparam int OFF_W     = $clog2(LINE_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  tvop_e                 op,
    input  logic [IDX_W-1:0]      op_idx,
    input  logic [OFF_W-1:0]      op_off,
    input  logic [TAG_W-1:0]      op_tag,
    input  logic [LINE_WORDS-1:0] op_mask,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [TAG_W-1:0]      rd_tag,
    output logic [LINE_WORDS-1:0] rd_valid
);
    logic [TAG_W-1:0]      tag_q   [LINES];
    logic [LINE_WORDS-1:0] valid_q [LINES];

    for (genvar l = 0; l < LINES; l++) begin : g_line
        // Update one line's tag and valid bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[l]   <= '0;
                valid_q[l] <= '0;
            end else if (op_idx == IDX_W'(l)) begin
                case (op)
                    TV_SETW:  valid_q[l][op_off] <= 1'b1;
                    TV_CLRW:  valid_q[l][op_off] <= 1'b0;
                    TV_ALLOC: begin
                        tag_q[l]   <= op_tag;
                        valid_q[l] <= op_mask;
                    end
                    default: ;
                endcase
            end
        end

        // R1: a cycle after reset the line holds no valid word.
        a_r1_valid_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (valid_q[l] == '0));
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
endmodule

// File: rtl/wtc_words.sv
// Cache data array: one write port, one combinational read port.
// Assumes contents are meaningful only where the valid store says so.
module wtc_words #(
    parameter int LINES      = 4,
    parameter int LINE_WORDS = 4,
    parameter int DATA_W     = 16,
    localparam int DEPTH     = LINES * LINE_WORDS,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Store one word when enabled.
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/wt_cache_ctrl.sv
// Direct-mapped write-through cache controller with per-word valid bits,
// selectable store-miss policy and optional speculative array stores.
// Assumes memory returns block beats in ascending offset order and
// acknowledges each word write once.
module wt_cache_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int LINE_WORDS = 4,
    parameter int LINES      = 4,
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int IDX_W     = $clog2(LINES),
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
    localparam int BLK_W     = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic [1:0]        wr_policy,
    input  logic              spec_write,
    output logic              mem_rd_req,
    output logic [BLK_W-1:0]  mem_rd_blk,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack
);
    cst_e              st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              we_q, spec_q;
    wpol_e             pol_q;
    logic [OFF_W-1:0]  beat_q;

    logic [OFF_W-1:0]  off_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    assign off_q = addr_q[OFF_W-1:0];
    assign idx_q = addr_q[OFF_W +: IDX_W];
    assign tag_q = addr_q[ADDR_W-1 -: TAG_W];

    // Store interfaces.
    tvop_e                 tv_op;
    logic [LINE_WORDS-1:0] tv_mask;
    logic [TAG_W-1:0]      tv_tag;
    logic [LINE_WORDS-1:0] tv_valid;
    logic                  dw_we;
    logic [IDX_W+OFF_W-1:0] dw_waddr;
    logic [DATA_W-1:0]     dw_wdata, dw_rdata;

    logic line_present, read_hit, last_beat;
    assign line_present = (tv_tag == tag_q) && (|tv_valid);
    assign read_hit     = line_present && tv_valid[off_q];
    assign last_beat    = (beat_q == OFF_W'(LINE_WORDS - 1));

    wtc_tagvalid #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)) u_tv (
        .clk(clk), .rst_n(rst_n), .op(tv_op), .op_idx(idx_q), .op_off(off_q),
        .op_tag(tag_q), .op_mask(tv_mask), .rd_idx(idx_q),
        .rd_tag(tv_tag), .rd_valid(tv_valid)
    );

    wtc_words #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_dw (
        .clk(clk), .we(dw_we), .waddr(dw_waddr), .wdata(dw_wdata),
        .raddr({idx_q, off_q}), .rdata(dw_rdata)
    );

    // Next state and store-port control.
    always_comb begin
        st_d     = st_q;
        tv_op    = TV_NONE;
        tv_mask  = '0;
        dw_we    = 1'b0;
        dw_waddr = {idx_q, off_q};
        dw_wdata = wdata_q;
        case (st_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    st_d = ST_LOOK;
                    if (cpu_we && spec_write) begin
                        dw_we    = 1'b1;
                        dw_waddr = cpu_addr[IDX_W+OFF_W-1:0];
                        dw_wdata = cpu_wdata;
                    end
                end
            end
            ST_LOOK: begin
                if (!we_q) begin
                    st_d = read_hit ? ST_IDLE : ST_FREQ;
                end else if (line_present) begin
                    dw_we = 1'b1;
                    tv_op = TV_SETW;
                    st_d  = ST_WMEM;
                end else begin
                    case (pol_q)
                        POL_FETCH: st_d = ST_FREQ;
                        POL_VALIDATE: begin
                            dw_we   = 1'b1;
                            tv_op   = TV_ALLOC;
                            tv_mask = LINE_WORDS'(1) << off_q;
                            st_d    = ST_WMEM;
                        end
                        default: begin
                            if (spec_q) tv_op = TV_CLRW;
                            st_d = ST_WMEM;
                        end
                    endcase
                end
            end
            ST_FREQ: st_d = ST_FILL;
            ST_FILL: begin
                if (mem_rd_valid) begin
                    dw_we    = 1'b1;
                    dw_waddr = {idx_q, beat_q};
                    dw_wdata = (we_q && beat_q == off_q) ? wdata_q : mem_rd_data;
                    if (last_beat) begin
                        tv_op   = TV_ALLOC;
                        tv_mask = '1;
                        st_d    = we_q ? ST_WMEM : ST_IDLE;
                    end
                end
            end
            ST_WMEM: if (mem_wr_ack) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State, request capture, beat counter and load result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            we_q    <= 1'b0;
            spec_q  <= 1'b0;
            pol_q   <= POL_FETCH;
            beat_q  <= '0;
        end else begin
            st_q <= st_d;
            case (st_q)
                ST_IDLE: if (cpu_req) begin
                    addr_q  <= cpu_addr;
                    wdata_q <= cpu_wdata;
                    we_q    <= cpu_we;
                    spec_q  <= spec_write;
                    pol_q   <= wpol_e'(wr_policy);
                end
                ST_LOOK: if (!we_q && read_hit) rdata_q <= dw_rdata;
                ST_FREQ: beat_q <= '0;
                ST_FILL: if (mem_rd_valid) begin
                    beat_q <= beat_q + 1'b1;
                    if (!we_q && beat_q == off_q) rdata_q <= mem_rd_data;
                end
                default: ;
            endcase
        end
    end

    assign cpu_ready   = (st_q == ST_IDLE);
    assign cpu_rdata   = rdata_q;
    assign mem_rd_req  = (st_q == ST_FREQ);
    assign mem_rd_blk  = addr_q[ADDR_W-1:OFF_W];
    assign mem_wr_req  = (st_q == ST_WMEM);
    assign mem_wr_addr = addr_q;
    assign mem_wr_data = wdata_q;

    // R10: no request accepted while memory traffic is in flight.
    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req || mem_rd_req) |-> !cpu_ready);
    // R10: a word write holds until acknowledged.
    a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));
    // R3: a block request lasts a single cycle.
    a_r3_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);
    // R2: a load hit finishes at once with no block read.
    a_r2_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOOK && !we_q && read_hit) |=> (cpu_ready && !mem_rd_req));
    // R7: validate miss leaves exactly one valid word under the new tag.
    a_r7_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOOK && we_q && !line_present && pol_q == POL_VALIDATE)
        |=> ($countones(tv_valid) == 1 && tv_valid[off_q] && tv_tag == tag_q));
    // R8: speculative around-miss invalidates the overwritten word.
    a_r8_spec_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOOK && we_q && spec_q && !line_present &&
         (pol_q == POL_AROUND || pol_q == POL_AROUND2)) |=> !tv_valid[off_q]);
endmodule

// File: tb/sim_wt_cache_ctrl.sv
module sim_wt_cache_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 2;
    localparam int AW = 8, DW = 16, LW = 4, NL = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0, spec_write = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
    logic cpu_ready;
    logic [1:0] wr_policy = 2'd0;
    logic mem_rd_req, mem_rd_valid, mem_wr_req, mem_wr_ack;
    logic [AW-3:0] mem_rd_blk;
    logic [DW-1:0] mem_rd_data, mem_wr_data;
    logic [AW-1:0] mem_wr_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    wt_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINE_WORDS(LW), .LINES(NL)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .wr_policy(wr_policy), .spec_write(spec_write),
        .mem_rd_req(mem_rd_req), .mem_rd_blk(mem_rd_blk), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
    );

    // Memory model with fixed latency.
    logic [DW-1:0] mem [256];
    logic rd_busy, wr_busy;
    int   rd_cnt, wr_cnt, fills, wrs;
    logic [AW-3:0] rd_base;
    logic [1:0] rd_beat;
    assign mem_rd_valid = rd_busy && rd_cnt == 0;
    assign mem_rd_data  = mem[{rd_base, rd_beat}];
    assign mem_wr_ack   = wr_busy && wr_cnt == 0;

    function automatic logic [DW-1:0] init_word(input int a);
        return DW'(a * 257) ^ 16'h5A3C;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 256; a++) mem[a] <= init_word(a);
            rd_busy <= 1'b0; wr_busy <= 1'b0; rd_cnt <= 0; wr_cnt <= 0;
            fills <= 0; wrs <= 0; rd_base <= '0; rd_beat <= '0;
        end else begin
            if (mem_rd_req) begin
                rd_busy <= 1'b1; rd_cnt <= MEM_LAT; rd_base <= mem_rd_blk;
                rd_beat <= '0; fills <= fills + 1;
            end else if (rd_busy) begin
                if (rd_cnt != 0) rd_cnt <= rd_cnt - 1;
                else begin
                    rd_beat <= rd_beat + 1'b1;
                    if (rd_beat == 2'd3) rd_busy <= 1'b0;
                end
            end
            if (mem_wr_req && !wr_busy) begin
                wr_busy <= 1'b1; wr_cnt <= MEM_LAT;
            end else if (wr_busy) begin
                if (wr_cnt != 0) wr_cnt <= wr_cnt - 1;
                else begin
                    mem[mem_wr_addr] <= mem_wr_data;
                    wr_busy <= 1'b0; wrs <= wrs + 1;
                end
            end
        end
    end

    // Reference state.
    logic [DW-1:0] ref_mem [256];
    logic [3:0] rt [NL];
    logic [3:0] rv [NL];
    int vecs = 0, miss = 0;
    logic [1:0] cur_pol = 2'd0;
    logic cur_spec = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            miss++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cpu_req = 1'b0;
        repeat (3) @(negedge clk);
        for (int a = 0; a < 256; a++) ref_mem[a] = init_word(a);
        for (int l = 0; l < NL; l++) begin rt[l] = '0; rv[l] = '0; end
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_ready && !mem_rd_req && !mem_wr_req, "R1", {cpu_ready, mem_rd_req, mem_wr_req}, 3'b100);
    endtask

    // One CPU request with expected traffic and data from the reference.
    task automatic do_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [1:0] mid_pol, input string tagov);
        logic [3:0] t; logic [1:0] ix, o;
        int exp_fill, f0, w0, busy;
        bit hit;
        string tg;
        t = a[7:4]; ix = a[3:2]; o = a[1:0];
        exp_fill = 0;
        hit = 1'b0;
        if (!we) begin
            hit = (rt[ix] == t) && rv[ix][o];
            tg = hit ? "R2" : "R3";
            if (!hit) begin exp_fill = 1; rt[ix] = t; rv[ix] = 4'hF; end
        end else begin
            if (rt[ix] == t && rv[ix] != 0) begin
                rv[ix][o] = 1'b1; tg = "R4";
            end else if (cur_pol == 2'd0) begin
                exp_fill = 1; rt[ix] = t; rv[ix] = 4'hF; tg = cur_spec ? "R9" : "R5";
            end else if (cur_pol == 2'd2) begin
                rt[ix] = t; rv[ix] = 4'(1) << o; tg = cur_spec ? "R9" : "R7";
            end else begin
                if (cur_spec) rv[ix][o] = 1'b0;
                tg = cur_spec ? "R8" : "R6";
            end
            ref_mem[a] = d;
        end
        if (tagov != "") tg = tagov;
        f0 = fills; w0 = wrs;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
        wr_policy = mid_pol;
        busy = 0;
        while (!cpu_ready && busy < 500) begin busy++; @(negedge clk); end
        wr_policy = cur_pol;
        chk(busy < 500, "R10", busy, 0);
        chk(fills - f0 == exp_fill, tg, fills - f0, exp_fill);
        chk(wrs - w0 == int'(we), tg, wrs - w0, int'(we));
        if (!we) begin
            chk(cpu_rdata == ref_mem[a], tg, cpu_rdata, ref_mem[a]);
            if (hit) chk(busy == 1, "R2", busy, 1);
        end else begin
            chk(mem[a] == d, tg, mem[a], d);
            chk(busy >= MEM_LAT + 1, "R10", busy, MEM_LAT + 1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miss++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        // R1: contents do not survive reset.
        do_reset();
        do_op(1'b0, 8'h21, '0, 2'd0, "");
        do_reset();
        do_op(1'b0, 8'h21, '0, 2'd0, "R1");

        // Sweep every policy code with and without speculative stores.
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 2; s++) begin
                cur_pol = 2'(p); cur_spec = 1'(s);
                wr_policy = cur_pol; spec_write = cur_spec;
                do_reset();
                for (int i = 0; i < 48; i++) begin
                    logic [3:0] t; logic [1:0] ix, o; logic w;
                    t  = 4'((i * 7) % 3);
                    ix = 2'((i >> 2) & 1);
                    o  = 2'((i * 3) % 4);
                    w  = (i % 3 == 1) || (i % 5 == 0);
                    do_op(w, {t, ix, o}, DW'(i * 911 + p * 77 + s), cur_pol, "");
                end
            end
        end

        // R8: speculative around-miss drops only the overwritten word.
        cur_pol = 2'd1; cur_spec = 1'b1; wr_policy = 2'd1; spec_write = 1'b1;
        do_reset();
        do_op(1'b0, 8'h04, '0, 2'd1, "R8");
        do_op(1'b1, 8'h14, 16'hBEEF, 2'd1, "R8");
        do_op(1'b0, 8'h05, '0, 2'd1, "R8");
        do_op(1'b0, 8'h04, '0, 2'd1, "R8");

        // R6: plain around-miss keeps the old line fully valid.
        cur_spec = 1'b0; spec_write = 1'b0;
        do_reset();
        do_op(1'b0, 8'h08, '0, 2'd1, "R6");
        do_op(1'b1, 8'h38, 16'h1234, 2'd1, "R6");
        do_op(1'b0, 8'h08, '0, 2'd1, "R6");

        // R11: policy changed mid-request has no effect on that request.
        cur_pol = 2'd2; wr_policy = 2'd2;
        do_reset();
        do_op(1'b1, 8'h24, 16'h7777, 2'd0, "R11");
        do_op(1'b0, 8'h25, '0, 2'd2, "R11");
        do_op(1'b0, 8'h24, '0, 2'd2, "R11");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end
endmodule